// File: doc/BRIEF.md
# Space Vector Dwell Time Calculator

This block turns a reference voltage angle and amplitude into the three dwell times one half of a modulation period needs, on a reference plane cut into six equal 60-degree sectors. It is meant for a reduced four-switch three-phase inverter. A later stage halves these six-sector durations and splits them across pairs of base vectors. The caller provides an unsigned phase word for the angle, a modulation index in unsigned Q1.15, and the sampling period as a count of clock cycles. It then pulses `start`. Some cycles later the block reports the sector number (1 to 6), the first and second active durations and the zero-vector duration, all counted in clock cycles for half the period.

The datapath is built around a shared multiplier and a single quarter-wave sine table, and a small state machine sequences it. Its states are IDLE, SPLIT, LOOK_A, LOOK_B, MUL_B and FINISH:

- IDLE moves to SPLIT when `start` is sampled high. Otherwise it stays in IDLE.
- SPLIT, LOOK_A, LOOK_B and MUL_B each pass to the next state after one cycle.
- FINISH always returns to IDLE, updates the outputs and raises `result_valid`.

During the computation:

- SPLIT separates the sector from the in-sector angle and forms the scaled amplitude.
- LOOK_A and LOOK_B read the two sines.
- LOOK_B and MUL_B form the two active times.
- FINISH derives the zero time and the saturation flag.

The results are held until the next result replaces them.

Top module: `svm_dwell_calc`

## Requirements
- R1: The reported sector equals floor(6·phase/2^16)+1, so it always lies in 1..6. The in-sector angle α is the fractional part of 6·phase/2^16 multiplied by 60 degrees.
- R2: `t_first` equals M·H·sin(60° − α) within 3 + 0.25 % of M·H counts. Here M = `mod_index`/32768 and H = floor(`period`/2).
- R3: `t_second` equals M·H·sin(α) within the same tolerance as R2.
- R4: When the two active times sum to at most H, `saturated` is 0 and `t_zero` equals exactly H − `t_first` − `t_second`. This includes M = 0, which gives active times of 0 and a zero time of H.
- R5: When `t_first` + `t_second` exceeds H, `t_zero` is 0 and `saturated` is 1. The active times themselves are not clamped.
- R6: `result_valid` is high for exactly one cycle, right after the fifth rising edge that follows the edge at which `start` is sampled. The new outputs appear in that same cycle.
- R7: Between results, all outputs hold their values whatever `phase`, `mod_index` and `period` do.
- R8: A `start` pulse that arrives while a computation is running is ignored. The running computation completes with its original inputs, and no extra result follows.
- R9: While reset is asserted and afterwards until the first result, `result_valid`, `sector`, all three durations and `saturated` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one computation when idle |
| phase | input | PHASE_W | Reference angle, full circle = 2^PHASE_W |
| mod_index | input | MOD_W | Modulation index, unsigned Q1.15 |
| period | input | TIME_W | Sampling period in clock cycles |
| result_valid | output | 1 | One-cycle pulse when new results are presented |
| sector | output | 3 | Sector number 1..6 |
| t_first | output | TIME_W | First active vector time for the half period |
| t_second | output | TIME_W | Second active vector time for the half period |
| t_zero | output | TIME_W | Zero vector time for the half period |
| saturated | output | 1 | Active times together exceed the half period |

## Verification
The bench builds the block with its default parameters:

- a 16-bit phase word;
- a 16-bit Q1.15 modulation index;
- a 16-bit period;
- a 1024-entry, 16-bit sine table.

These widths let the stimulus reach every sector, both ends of a sector (α at 0 and just under 60 degrees) and an odd period, where the half period is truncated. At the top of the range, an index just under 2.0 combined with the largest period drives both active times close to full scale and pushes the block well into saturation. With these widths, the R2 and R3 tolerance covers the quantisation of both the table and the angle.

// File: rtl/svm_pkg.sv
package svm_pkg;

    // Sequencing states of the dwell calculator
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SPLIT  = 3'd1,
        S_LOOK_A = 3'd2,
        S_LOOK_B = 3'd3,
        S_MUL_B  = 3'd4,
        S_FINISH = 3'd5
    } svm_state_e;

    // pi scaled by 2^30, used when the sine table is computed
    localparam longint PI_Q30 = 64'd3373259426;

endpackage

// File: rtl/svm_sine_rom.sv
module svm_sine_rom #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    import svm_pkg::*;

    localparam int     DEPTH = 1 << AW;
    localparam longint STEP  = PI_Q30 >>> (AW + 1);
    localparam longint TOP   = (longint'(1) << DW) - 1;

    // sin(idx * pi / 2^(AW+1)) in Q30, odd Taylor series up to x^11
    function automatic longint sine_q30(input int idx);
        longint x;
        longint term;
        longint sum;
        x    = longint'(idx) * STEP;
        term = x;
        sum  = x;
        for (int n = 1; n <= 5; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -term / longint'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        return sum;
    endfunction

    function automatic logic [DW-1:0] entry(input int idx);
        longint s;
        s = (sine_q30(idx) * TOP) >>> 30;
        if (s < 0)   s = 0;
        if (s > TOP) s = TOP;
        return DW'(s);
    endfunction

    logic [DW-1:0] lut [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lut
        assign lut[g] = entry(g);
    end

    assign data = lut[addr];

endmodule

// File: rtl/svm_mul.sv
module svm_mul #(
    parameter int AW = 16,
    parameter int BW = 16
) (
    input  logic [AW-1:0]    a,
    input  logic [BW-1:0]    b,
    output logic [AW+BW-1:0] p
);
    assign p = a * b;
endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc #(
    parameter int PHASE_W = 16,
    parameter int MOD_W   = 16,
    parameter int TIME_W  = 16,
    parameter int LUT_AW  = 10,
    parameter int LUT_DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PHASE_W-1:0] phase,
    input  logic [MOD_W-1:0]  mod_index,
    input  logic [TIME_W-1:0] period,
    output logic              result_valid,
    output logic [2:0]        sector,
    output logic [TIME_W-1:0] t_first,
    output logic [TIME_W-1:0] t_second,
    output logic [TIME_W-1:0] t_zero,
    output logic              saturated
);
    import svm_pkg::*;

    // operand width of the shared multiplier
    localparam int OPW_0 = (TIME_W > MOD_W) ? TIME_W : MOD_W;
    localparam int OPW   = (OPW_0 > LUT_DW) ? OPW_0 : LUT_DW;
    // 2^(LUT_AW+1)/3 maps a sector fraction onto the quarter-wave address range
    localparam logic [31:0]      SCALE60 = 32'(((1 << (LUT_AW + 1)) + 1) / 3);
    localparam logic [PHASE_W:0] FULL    = (PHASE_W+1)'(1) << PHASE_W;

    svm_state_e state_q, state_d;

    logic [PHASE_W+2:0] phase6;
    logic [2:0]         sec_q;
    logic [PHASE_W-1:0] frac_q;
    logic [MOD_W-1:0]   mod_q;
    logic [TIME_W-1:0]  half_q;
    logic [TIME_W-1:0]  k_q;
    logic [LUT_AW-1:0]  idx_a_q, idx_b_q;
    logic [LUT_DW-1:0]  sin_q;
    logic [TIME_W-1:0]  acc_a_q, acc_b_q;
    logic [TIME_W:0]    sum_ab;
    logic [LUT_AW-1:0]  rom_addr;
    logic [LUT_DW-1:0]  rom_data;
    logic [OPW-1:0]     op_a, op_b;
    logic [2*OPW-1:0]   prod;

    assign phase6   = (PHASE_W+3)'(phase) * (PHASE_W+3)'(6);
    assign sum_ab   = {1'b0, acc_a_q} + {1'b0, acc_b_q};
    assign rom_addr = (state_q == S_LOOK_B) ? idx_b_q : idx_a_q;
    assign op_a     = (state_q == S_SPLIT) ? OPW'(mod_q)  : OPW'(k_q);
    assign op_b     = (state_q == S_SPLIT) ? OPW'(half_q) : OPW'(sin_q);

    svm_sine_rom #(.AW(LUT_AW), .DW(LUT_DW)) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    svm_mul #(.AW(OPW), .BW(OPW)) u_mul (
        .a (op_a),
        .b (op_b),
        .p (prod)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_SPLIT;
            S_SPLIT:  state_d = S_LOOK_A;
            S_LOOK_A: state_d = S_LOOK_B;
            S_LOOK_B: state_d = S_MUL_B;
            S_MUL_B:  state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q        <= '0;
            frac_q       <= '0;
            mod_q        <= '0;
            half_q       <= '0;
            k_q          <= '0;
            idx_a_q      <= '0;
            idx_b_q      <= '0;
            sin_q        <= '0;
            acc_a_q      <= '0;
            acc_b_q      <= '0;
            result_valid <= 1'b0;
            sector       <= '0;
            t_first      <= '0;
            t_second     <= '0;
            t_zero       <= '0;
            saturated    <= 1'b0;
        end else begin
            result_valid <= (state_q == S_FINISH);
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        sec_q  <= phase6[PHASE_W+2:PHASE_W];
                        frac_q <= phase6[PHASE_W-1:0];
                        mod_q  <= mod_index;
                        half_q <= TIME_W'(period >> 1);
                    end
                end
                S_SPLIT: begin
                    k_q     <= TIME_W'(prod >> (MOD_W - 1));
                    idx_a_q <= LUT_AW'(((FULL - {1'b0, frac_q}) * SCALE60) >> PHASE_W);
                    idx_b_q <= LUT_AW'(({1'b0, frac_q} * SCALE60) >> PHASE_W);
                end
                S_LOOK_A: begin
                    sin_q <= rom_data;
                end
                S_LOOK_B: begin
                    acc_a_q <= TIME_W'(prod >> LUT_DW);
                    sin_q   <= rom_data;
                end
                S_MUL_B: begin
                    acc_b_q <= TIME_W'(prod >> LUT_DW);
                end
                S_FINISH: begin
                    sector   <= sec_q + 3'd1;
                    t_first  <= acc_a_q;
                    t_second <= acc_b_q;
                    if (sum_ab > {1'b0, half_q}) begin
                        t_zero    <= '0;
                        saturated <= 1'b1;
                    end else begin
                        t_zero    <= TIME_W'({1'b0, half_q} - sum_ab);
                        saturated <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (sector >= 3'd1 && sector <= 3'd6)); // R1
    AST_ZERO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (t_zero <= half_q)); // R4
    AST_SAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && saturated) |-> (({1'b0, t_first} + {1'b0, t_second}) > {1'b0, half_q})); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6
    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == S_IDLE) |=> (state_q == S_SPLIT)); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(t_first) && $stable(t_second) && $stable(t_zero)
                           && $stable(sector) && $stable(saturated))); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != S_IDLE) |=> (state_q != S_SPLIT)); // R8

endmodule

// File: tb/svm_dwell_calc_bench.sv
`timescale 1ns/1ps
module svm_dwell_calc_bench;

    localparam real PI = 3.14159265358979;
    localparam int  NV = 10;
    // {phase, mod_index (Q1.15), period}
    localparam logic [47:0] VEC [NV] = '{
        {16'h0000, 16'd16384, 16'd1000},
        {16'h1555, 16'd26214, 16'd2000},
        {16'h4000, 16'd19661, 16'd4000},
        {16'h8000, 16'd29491, 16'd10000},
        {16'hAAAA, 16'd22938, 16'd3000},
        {16'hD000, 16'd9830,  16'd60000},
        {16'hF000, 16'd31130, 16'd1000},
        {16'h3000, 16'd0,     16'd1001},
        {16'h1555, 16'd49152, 16'd1000},
        {16'h9555, 16'd65535, 16'd65535}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] phase = '0;
    logic [15:0] mod_index = '0;
    logic [15:0] period = '0;
    logic        result_valid;
    logic [2:0]  sector;
    logic [15:0] t_first, t_second, t_zero;
    logic        saturated;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    svm_dwell_calc u_svm_dwell_calc (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .phase        (phase),
        .mod_index    (mod_index),
        .period       (period),
        .result_valid (result_valid),
        .sector       (sector),
        .t_first      (t_first),
        .t_second     (t_second),
        .t_zero       (t_zero),
        .saturated    (saturated)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // launch one computation and verify the R6 latency
    task automatic launch(input logic [15:0] ph, input logic [15:0] m, input logic [15:0] per);
        bit early;
        @(negedge clk);
        phase = ph; mod_index = m; period = per; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early = 1'b0;
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            if (result_valid) early = 1'b1;
        end
        chk(!early, "R6 no early valid", early, 0);
        @(negedge clk);
        chk(result_valid == 1'b1, "R6 valid at latency", result_valid, 1);
    endtask

    task automatic run_vector(input logic [15:0] ph, input logic [15:0] m, input logic [15:0] per);
        int  sec_e, half;
        real frac, alpha, mr, e1, e2, tol, d1, d2;
        sec_e = (int'(ph) * 6) / 65536 + 1;
        frac  = real'((int'(ph) * 6) % 65536) / 65536.0;
        alpha = frac * PI / 3.0;
        mr    = real'(m) / 32768.0;
        half  = int'(per) / 2;
        e1    = mr * real'(half) * $sin(PI / 3.0 - alpha);
        e2    = mr * real'(half) * $sin(alpha);
        tol   = 3.0 + mr * real'(half) * 0.0025;
        launch(ph, m, per);
        d1 = real'(t_first) - e1;  if (d1 < 0.0) d1 = -d1;
        d2 = real'(t_second) - e2; if (d2 < 0.0) d2 = -d2;
        chk(sector == 3'(sec_e), "R1 sector", sector, sec_e);
        chk(d1 <= tol, "R2 first active time", t_first, longint'(e1));
        chk(d2 <= tol, "R3 second active time", t_second, longint'(e2));
        if (e1 + e2 > real'(half)) begin
            chk(saturated == 1'b1, "R5 saturation flag", saturated, 1);
            chk(t_zero == 16'd0, "R5 zero time clamped", t_zero, 0);
        end else begin
            chk(saturated == 1'b0, "R4 no saturation", saturated, 0);
            chk(int'(t_zero) == half - int'(t_first) - int'(t_second), "R4 zero time",
                t_zero, half - int'(t_first) - int'(t_second));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] sa_first, sa_second, sa_zero;
        logic [2:0]  sa_sector;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk({result_valid, sector, t_first, t_second, t_zero, saturated} == '0,
            "R9 outputs during reset", t_first, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({result_valid, sector, t_first, t_second, t_zero, saturated} == '0,
            "R9 outputs after reset", {sector, result_valid}, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            run_vector(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
            @(negedge clk);
            chk(result_valid == 1'b0, "R6 single-cycle pulse", result_valid, 0);
        end

        // M = 0, odd period: zero time is the whole truncated half period (R4)
        launch(16'h3000, 16'd0, 16'd1001);
        chk(t_first == 0 && t_second == 0, "R4 zero index active times", t_first + t_second, 0);
        chk(t_zero == 16'd500, "R4 zero index zero time", t_zero, 500);

        // R7: outputs hold while inputs wander without start
        launch(16'h4000, 16'd19661, 16'd4000);
        sa_first = t_first; sa_second = t_second; sa_zero = t_zero; sa_sector = sector;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            phase = 16'(c * 7919); mod_index = 16'(c * 3001); period = 16'(c * 123 + 7);
        end
        chk(t_first == sa_first && t_second == sa_second && t_zero == sa_zero &&
            sector == sa_sector && result_valid == 1'b0, "R7 outputs held", t_first, sa_first);

        // R8: start during a computation is ignored
        @(negedge clk);
        phase = 16'h4000; mod_index = 16'd19661; period = 16'd4000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        phase = 16'h8000; mod_index = 16'd29491; period = 16'd10000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(result_valid == 1'b1, "R8 first result on time", result_valid, 1);
        chk(t_first == sa_first && t_second == sa_second && t_zero == sa_zero &&
            sector == sa_sector, "R8 result uses original inputs", t_first, sa_first);
        begin
            bit extra;
            extra = 1'b0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (result_valid) extra = 1'b1;
            end
            chk(!extra, "R8 no second result", extra, 0);
        end

        // block still usable afterwards
        run_vector(16'hD000, 16'd9830, 16'd60000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule